// File: doc/BRIEF.md
# Center-Aligned PWM Timer (16-bit, byte access)

This block is a 16-bit timer/counter with a byte-wide register port. When PWM is off it counts up and wraps. In one of three PWM resolutions it counts from zero up to a top value and back down to zero. A compare register sets or clears a registered output pin whenever the count passes the compare value, so the high part of each pulse is centred in the period. In PWM mode a compare value written by the host is held as pending. It becomes active only when the count arrives at the top value, so a duty change never breaks up a pulse.

The host reaches the 16-bit counter and compare values through one shared temporary byte, which makes each 16-bit access atomic. The counting clock is a tick chosen from a free-running prescaler, the system clock itself, a synchronised external pin (rising or falling edge), or nothing (stopped). Two sticky flags report when the count arrives at zero and when it arrives at the compare value.

Top module: `dspwm_timer`

## Requirements
- R1: After reset the counter, the pending and active compare values, the temporary byte, the flags and `pwm_out` are all zero, PWM is off (mode 0), and the clock select is 0 (stopped), so the counter holds its value.
- R2: Register addresses are 0 mode, 1 clock select, 2 counter low, 3 counter high, 4 compare low, 5 compare high, 6 flags. A write to address 3 or 5 only loads the shared temporary byte. A write to address 2 or 4 commits {temporary, data} as the 16-bit value. A read of address 2 or 4 returns the low byte and copies that register's high byte into the temporary byte. A read of address 3 or 5 returns the temporary byte.
- R3: A counter write replaces the count on that edge and no tick is applied there. The next tick advances from the written value.
- R4: Clock select codes (bits 2:0 of address 1) are 0 stop, 1 every system clock, 2 one tick in 8, 3 one tick in 64, 4 one tick in 256, 5 one tick in 1024, 6 rising edge of `ext_clk_pin`, 7 falling edge of `ext_clk_pin`. The pin passes through a two-flop synchroniser.
- R5: Mode codes (bits 1:0 of address 0) are 0 off, 1 top 255, 2 top 511, 3 top 1023. With mode 0 the counter counts up through 16 bits and wraps, and `pwm_out` is low.
- R6: In PWM mode each tick moves the count by one. Counting up, a count at or above the top value turns downward (a count written above the top value decreases by one on the next tick). Counting down, zero turns upward. One full period is twice the top value in ticks.
- R7: In PWM mode a compare write updates only the pending value. The active value takes the pending value on the tick that brings the count to the top value. With mode 0 a compare write updates both values at once.
- R8: A compare read (address 4, then 5) returns the pending value, including a value not yet made active.
- R9: A tick that brings the count to the active compare value clears `pwm_out` when counting up and sets it when counting down. Two exceptions apply: a compare of 0 always clears and a compare equal to the top value always sets. In steady PWM operation `pwm_out` is high for exactly twice the compare value in ticks per period.
- R10: The overflow flag (bit 0 of address 6, port `ovf_flag`) is set by a tick that brings the count to zero.
- R11: The compare flag (bit 1 of address 6, port `cmp_flag`) is set by a tick that brings the count to the active compare value.
- R12: Writing 1 to a flag bit at address 6 clears that flag and writing 0 leaves it unchanged. A set on the same edge wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe (triggers the high-byte capture) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| ext_clk_pin | input | 1 | External counting clock pin |
| pwm_out | output | 1 | Registered PWM output |
| ovf_flag | output | 1 | Sticky flag: count reached zero |
| cmp_flag | output | 1 | Sticky flag: count reached the active compare value |

## Verification
A wrong direction bit or top value changes the number of high ticks in the very next period, so sweeping the duty over the compare values of each resolution exposes it within two periods. If the compare value were made active too early, the output would switch when the count passes the pending value, and the compare flag would rise there instead of at the active value. This shows up within one half period when the count is started above both values. Prescaler or synchroniser faults change the tick count across a fixed window of system cycles, which can be read back through the counter bytes as soon as that window ends.

// File: rtl/pwmtmr_pkg.sv
`timescale 1ns/1ps
package pwmtmr_pkg;

  localparam int ADR_W = 3;

  localparam logic [ADR_W-1:0] ADR_MODE   = 3'd0;
  localparam logic [ADR_W-1:0] ADR_CLK    = 3'd1;
  localparam logic [ADR_W-1:0] ADR_CNT_LO = 3'd2;
  localparam logic [ADR_W-1:0] ADR_CNT_HI = 3'd3;
  localparam logic [ADR_W-1:0] ADR_CMP_LO = 3'd4;
  localparam logic [ADR_W-1:0] ADR_CMP_HI = 3'd5;
  localparam logic [ADR_W-1:0] ADR_FLAG   = 3'd6;

  typedef enum logic [1:0] {
    RES_OFF = 2'd0,
    RES_LO  = 2'd1,
    RES_MID = 2'd2,
    RES_HI  = 2'd3
  } res_mode_e;

  typedef enum logic [2:0] {
    CS_STOP   = 3'd0,
    CS_SYS    = 3'd1,
    CS_DIV_A  = 3'd2,
    CS_DIV_B  = 3'd3,
    CS_DIV_C  = 3'd4,
    CS_DIV_D  = 3'd5,
    CS_EXT_RI = 3'd6,
    CS_EXT_FA = 3'd7
  } clk_sel_e;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } cnt_dir_e;

endpackage

// File: rtl/pwmtmr_rstsync.sv
`timescale 1ns/1ps
module pwmtmr_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pwmtmr_prescale.sv
`timescale 1ns/1ps
module pwmtmr_prescale
  import pwmtmr_pkg::*;
#(
  parameter int SH_A = 3,
  parameter int SH_B = 6,
  parameter int SH_C = 8,
  parameter int SH_D = 10
) (
  input  logic     clk,
  input  logic     rst_n,
  input  clk_sel_e sel,
  input  logic     ext_pin,
  output logic     tick
);

  localparam int PRE_W  = SH_D;
  localparam int N_TAPS = 4;
  localparam int SHIFTS [N_TAPS] = '{SH_A, SH_B, SH_C, SH_D};

  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [2:0]        pin_q, pin_d;
  logic [N_TAPS-1:0] tap_hit;
  logic              ext_rise, ext_fall;

  // free-running divider, shared by all taps
  always_comb begin
    pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end

  generate
    for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
      assign tap_hit[g] = &pre_q[SHIFTS[g]-1:0];
    end
  endgenerate

  // two synchronising stages plus one history stage
  always_comb begin
    pin_d = {pin_q[1:0], ext_pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= '0;
    end else begin
      pin_q <= pin_d;
    end
  end

  assign ext_rise =  pin_q[1] & ~pin_q[2];
  assign ext_fall = ~pin_q[1] &  pin_q[2];

  always_comb begin
    unique case (sel)
      CS_STOP:   tick = 1'b0;
      CS_SYS:    tick = 1'b1;
      CS_DIV_A:  tick = tap_hit[0];
      CS_DIV_B:  tick = tap_hit[1];
      CS_DIV_C:  tick = tap_hit[2];
      CS_DIV_D:  tick = tap_hit[3];
      CS_EXT_RI: tick = ext_rise;
      CS_EXT_FA: tick = ext_fall;
      default:   tick = 1'b0;
    endcase
  end

endmodule

// File: rtl/pwmtmr_regs.sv
`timescale 1ns/1ps
module pwmtmr_regs
  import pwmtmr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADR_W-1:0]  bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [2*DATA_W-1:0] cnt_val,
  input  logic [2*DATA_W-1:0] pend_val,
  input  logic              ovf_hit,
  input  logic              cmp_hit,
  output res_mode_e         mode,
  output clk_sel_e          csel,
  output logic              cnt_wr,
  output logic              cmp_wr,
  output logic [2*DATA_W-1:0] wide_wdata,
  output logic              ovf_flag,
  output logic              cmp_flag
);

  logic [DATA_W-1:0] temp_q, temp_d;
  res_mode_e         mode_d;
  clk_sel_e          csel_d;
  logic              ovf_d, cmp_d;
  logic              wr_mode, wr_clk, wr_hi, wr_flag;
  logic              rd_cnt_lo, rd_cmp_lo;

  // address decode
  always_comb begin
    wr_mode   = bus_wr && (bus_addr == ADR_MODE);
    wr_clk    = bus_wr && (bus_addr == ADR_CLK);
    wr_hi     = bus_wr && ((bus_addr == ADR_CNT_HI) || (bus_addr == ADR_CMP_HI));
    wr_flag   = bus_wr && (bus_addr == ADR_FLAG);
    cnt_wr    = bus_wr && (bus_addr == ADR_CNT_LO);
    cmp_wr    = bus_wr && (bus_addr == ADR_CMP_LO);
    rd_cnt_lo = bus_rd && !bus_wr && (bus_addr == ADR_CNT_LO);
    rd_cmp_lo = bus_rd && !bus_wr && (bus_addr == ADR_CMP_LO);
    wide_wdata = {temp_q, bus_wdata};
  end

  // next state
  always_comb begin
    mode_d = mode;
    csel_d = csel;
    temp_d = temp_q;
    if (wr_mode) mode_d = res_mode_e'(bus_wdata[1:0]);
    if (wr_clk)  csel_d = clk_sel_e'(bus_wdata[2:0]);
    if (wr_hi) begin
      temp_d = bus_wdata;
    end else if (rd_cnt_lo) begin
      temp_d = cnt_val[2*DATA_W-1:DATA_W];
    end else if (rd_cmp_lo) begin
      temp_d = pend_val[2*DATA_W-1:DATA_W];
    end
    ovf_d = ovf_hit | (ovf_flag & ~(wr_flag & bus_wdata[0]));
    cmp_d = cmp_hit | (cmp_flag & ~(wr_flag & bus_wdata[1]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= RES_OFF;
      csel     <= CS_STOP;
      temp_q   <= '0;
      ovf_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      mode     <= mode_d;
      csel     <= csel_d;
      temp_q   <= temp_d;
      ovf_flag <= ovf_d;
      cmp_flag <= cmp_d;
    end
  end

  // read mux
  always_comb begin
    unique case (bus_addr)
      ADR_MODE:   bus_rdata = {{(DATA_W-2){1'b0}}, mode};
      ADR_CLK:    bus_rdata = {{(DATA_W-3){1'b0}}, csel};
      ADR_CNT_LO: bus_rdata = cnt_val[DATA_W-1:0];
      ADR_CNT_HI: bus_rdata = temp_q;
      ADR_CMP_LO: bus_rdata = pend_val[DATA_W-1:0];
      ADR_CMP_HI: bus_rdata = temp_q;
      ADR_FLAG:   bus_rdata = {{(DATA_W-2){1'b0}}, cmp_flag, ovf_flag};
      default:    bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/pwmtmr_core.sv
`timescale 1ns/1ps
module pwmtmr_core
  import pwmtmr_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int BASE_RES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  res_mode_e        mode,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] pend_q,
  output logic [CNT_W-1:0] act_q,
  output logic [CNT_W-1:0] top_val,
  output logic             pwm_out,
  output logic             ovf_hit,
  output logic             cmp_hit
);

  localparam logic [CNT_W-1:0] TOP_LO  = CNT_W'((1 << BASE_RES) - 1);
  localparam logic [CNT_W-1:0] TOP_MID = CNT_W'((1 << (BASE_RES + 1)) - 1);
  localparam logic [CNT_W-1:0] TOP_HI  = CNT_W'((1 << (BASE_RES + 2)) - 1);

  logic [CNT_W-1:0] cnt_d, pend_d, act_d, step;
  cnt_dir_e         dir_q, dir_d, dir_step;
  logic             out_d, pwm_on, moved_up, arrive;

  always_comb begin
    unique case (mode)
      RES_LO:  top_val = TOP_LO;
      RES_MID: top_val = TOP_MID;
      RES_HI:  top_val = TOP_HI;
      default: top_val = '1;
    endcase
    pwm_on = (mode != RES_OFF);
  end

  // one counting step, used only when a tick lands
  always_comb begin
    dir_step = dir_q;
    if (!pwm_on) begin
      step     = cnt_q + 1'b1;
      moved_up = 1'b1;
    end else if (dir_q == DIR_UP) begin
      if (cnt_q >= top_val) begin
        step     = cnt_q - 1'b1;
        dir_step = DIR_DOWN;
        moved_up = 1'b0;
      end else begin
        step     = cnt_q + 1'b1;
        moved_up = 1'b1;
      end
    end else begin
      if (cnt_q == '0) begin
        step     = CNT_W'(1);
        dir_step = DIR_UP;
        moved_up = 1'b1;
      end else begin
        step     = cnt_q - 1'b1;
        moved_up = 1'b0;
      end
    end
  end

  // next state
  always_comb begin
    cnt_d  = cnt_q;
    dir_d  = dir_q;
    pend_d = pend_q;
    act_d  = act_q;
    arrive = 1'b0;
    if (cnt_wr) begin
      cnt_d = wdata;
    end else if (tick) begin
      cnt_d  = step;
      dir_d  = dir_step;
      arrive = 1'b1;
    end
    if (!pwm_on) dir_d = DIR_UP;

    if (cmp_wr) begin
      pend_d = wdata;
      if (!pwm_on) act_d = wdata;
    end
    if (pwm_on && arrive && (step == top_val)) act_d = pend_q;

    cmp_hit = arrive && (step == act_d);
    ovf_hit = arrive && (step == '0);

    out_d = pwm_out;
    if (!pwm_on) begin
      out_d = 1'b0;
    end else if (cmp_hit) begin
      if (act_d == '0)           out_d = 1'b0;
      else if (act_d == top_val) out_d = 1'b1;
      else                       out_d = ~moved_up;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      dir_q   <= DIR_UP;
      pend_q  <= '0;
      act_q   <= '0;
      pwm_out <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      dir_q   <= dir_d;
      pend_q  <= pend_d;
      act_q   <= act_d;
      pwm_out <= out_d;
    end
  end

endmodule

// File: rtl/dspwm_timer.sv
`timescale 1ns/1ps
module dspwm_timer
  import pwmtmr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int BASE_RES = 8,
  parameter int SH_A     = 3,
  parameter int SH_B     = 6,
  parameter int SH_C     = 8,
  parameter int SH_D     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADR_W-1:0]  bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ext_clk_pin,
  output logic              pwm_out,
  output logic              ovf_flag,
  output logic              cmp_flag
);

  localparam int CNT_W = 2 * DATA_W;

  logic             rst_core_n;
  res_mode_e        mode_w;
  clk_sel_e         csel_w;
  logic             tick_w, cnt_wr_w, cmp_wr_w, ovf_hit_w, cmp_hit_w;
  logic [CNT_W-1:0] wide_w, cnt_w, pend_w, act_w, top_w;

  pwmtmr_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_core_n)
  );

  pwmtmr_prescale #(.SH_A(SH_A), .SH_B(SH_B), .SH_C(SH_C), .SH_D(SH_D)) u_pre (
    .clk(clk), .rst_n(rst_core_n), .sel(csel_w), .ext_pin(ext_clk_pin), .tick(tick_w)
  );

  pwmtmr_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_core_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_val(cnt_w), .pend_val(pend_w),
    .ovf_hit(ovf_hit_w), .cmp_hit(cmp_hit_w),
    .mode(mode_w), .csel(csel_w),
    .cnt_wr(cnt_wr_w), .cmp_wr(cmp_wr_w), .wide_wdata(wide_w),
    .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
  );

  pwmtmr_core #(.CNT_W(CNT_W), .BASE_RES(BASE_RES)) u_core (
    .clk(clk), .rst_n(rst_core_n), .mode(mode_w), .tick(tick_w),
    .cnt_wr(cnt_wr_w), .cmp_wr(cmp_wr_w), .wdata(wide_w),
    .cnt_q(cnt_w), .pend_q(pend_w), .act_q(act_w), .top_val(top_w),
    .pwm_out(pwm_out), .ovf_hit(ovf_hit_w), .cmp_hit(cmp_hit_w)
  );

endmodule

// File: rtl/pwmtmr_chk.sv
`timescale 1ns/1ps
module pwmtmr_chk
  import pwmtmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input res_mode_e         mode_i,
  input clk_sel_e          csel_i,
  input logic              tick_i,
  input logic              cnt_wr_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  act_i,
  input logic [CNT_W-1:0]  top_i,
  input logic              pwm_out_i,
  input logic              ovf_flag_i,
  input logic              cmp_flag_i,
  input logic              bus_wr_i,
  input logic [ADR_W-1:0]  bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i
);

  a_r4_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (csel_i == CS_STOP && !cnt_wr_i) |=> (cnt_i == $past(cnt_i)));

  a_r6_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != RES_OFF && tick_i && !cnt_wr_i && cnt_i <= top_i) |=>
      (cnt_i <= $past(top_i) &&
       (cnt_i == $past(cnt_i) + 1'b1 || cnt_i == $past(cnt_i) - 1'b1)));

  a_r7_latch_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != RES_OFF && mode_i == $past(mode_i) && act_i != $past(act_i)) |->
      (cnt_i == top_i));

  a_r5_out_low_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == RES_OFF && $past(mode_i) == RES_OFF) |-> !pwm_out_i);

  a_r10_ovf_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag_i) |-> (cnt_i == '0));

  a_r11_cmp_at_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_flag_i) |-> (cnt_i == act_i));

  a_r12_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag_i && !(bus_wr_i && bus_addr_i == ADR_FLAG && bus_wdata_i[0])) |=> ovf_flag_i);

endmodule

bind dspwm_timer pwmtmr_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .mode_i(mode_w), .csel_i(csel_w),
  .tick_i(tick_w), .cnt_wr_i(cnt_wr_w), .cnt_i(cnt_w), .act_i(act_w),
  .top_i(top_w), .pwm_out_i(pwm_out), .ovf_flag_i(ovf_flag),
  .cmp_flag_i(cmp_flag), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
  .bus_wdata_i(bus_wdata)
);

// File: tb/dspwm_timer_tb.sv
`timescale 1ns/1ps
module dspwm_timer_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ext_clk_pin = 1'b0;
  logic       pwm_out, ovf_flag, cmp_flag;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dspwm_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_clk_pin(ext_clk_pin), .pwm_out(pwm_out),
    .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic wr8(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr16(input logic [2:0] lo_a, input logic [15:0] d);
    wr8(lo_a + 3'd1, d[15:8]);
    wr8(lo_a, d[7:0]);
  endtask

  task automatic rd8(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd16(input logic [2:0] lo_a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd8(lo_a, lo);
    rd8(lo_a + 3'd1, hi);
    d = {hi, lo};
  endtask

  task automatic tick_window(input logic [2:0] sel, input int win, input int exp, input string req);
    logic [15:0] c0, c1;
    wr8(3'd1, {5'd0, sel});
    rd16(3'd2, c0);
    repeat (win - 2) @(negedge clk);
    rd16(3'd2, c1);
    chk(req, 32'(c1 - c0), 32'(exp));
    wr8(3'd1, 8'd0);
  endtask

  task automatic ext_window(input logic [2:0] sel, input string req);
    logic [15:0] c0, c1;
    wr8(3'd1, {5'd0, sel});
    rd16(3'd2, c0);
    for (int p = 0; p < 20; p++) begin
      ext_clk_pin = 1'b1; repeat (3) @(negedge clk);
      ext_clk_pin = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    rd16(3'd2, c1);
    chk(req, 32'(c1 - c0), 32'd20);
    wr8(3'd1, 8'd0);
  endtask

  task automatic duty(input int m, input int cmp);
    int top;
    int highs;
    top = (1 << (7 + m)) - 1;
    highs = 0;
    wr8(3'd1, 8'd0);
    wr8(3'd0, 8'd0);
    wr16(3'd2, 16'd0);
    wr16(3'd4, 16'(cmp));
    wr8(3'd0, 8'(m));
    wr8(3'd1, 8'd1);
    repeat (2 * top) @(negedge clk);
    for (int k = 0; k < 2 * top; k++) begin
      if (pwm_out) highs++;
      @(negedge clk);
    end
    // R9 duty, R6 period and top per mode (R5)
    chk($sformatf("R9 duty mode=%0d cmp=%0d", m, cmp), 32'(highs), 32'(2 * cmp));
  endtask

  logic [7:0]  b;
  logic [15:0] w;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 pwm_out", 32'(pwm_out), 0);
    chk("R1 ovf_flag", 32'(ovf_flag), 0);
    chk("R1 cmp_flag", 32'(cmp_flag), 0);
    rd8(3'd0, b); chk("R1 mode", 32'(b), 0);
    rd8(3'd1, b); chk("R1 clock select", 32'(b), 0);
    repeat (10) @(negedge clk);
    rd16(3'd2, w); chk("R1 counter stopped at zero", 32'(w), 0);
    rd16(3'd4, w); chk("R1 compare", 32'(w), 0);

    // R2 16-bit access through the shared byte
    wr16(3'd2, 16'h1234);
    rd16(3'd2, w); chk("R2 counter readback", 32'(w), 32'h1234);
    wr8(3'd3, 8'hAB);
    wr8(3'd4, 8'hCD);
    rd16(3'd4, w); chk("R2 shared temp into compare", 32'(w), 32'hABCD);
    rd16(3'd2, w); chk("R2 high write alone keeps counter", 32'(w), 32'h1234);

    // R3 write wins over tick, counting resumes next tick
    wr8(3'd1, 8'd1);
    wr16(3'd2, 16'h0005);
    rd8(3'd2, b); chk("R3 written value, no tick on write edge", 32'(b), 32'h05);
    rd8(3'd2, b); chk("R3 next tick advances", 32'(b), 32'h06);
    wr8(3'd1, 8'd0);

    // R4 clock selects
    tick_window(3'd0, 100, 0, "R4 stop");
    tick_window(3'd1, 100, 100, "R4 system clock");
    tick_window(3'd2, 800, 100, "R4 div 8");
    tick_window(3'd3, 6400, 100, "R4 div 64");
    tick_window(3'd4, 2560, 10, "R4 div 256");
    tick_window(3'd5, 10240, 10, "R4 div 1024");
    ext_window(3'd6, "R4 external rising");
    ext_window(3'd7, "R4 external falling");

    // R10 R11 R12 in mode 0: wrap to zero, compare match, flag clearing
    wr16(3'd4, 16'hFFFF);
    wr16(3'd2, 16'hFFFE);
    wr8(3'd6, 8'h03);
    wr8(3'd1, 8'd1);
    chk("R10 no overflow yet", 32'(ovf_flag), 0);
    @(negedge clk);
    chk("R11 compare flag on reaching FFFF", 32'(cmp_flag), 1);
    chk("R10 still no overflow", 32'(ovf_flag), 0);
    @(negedge clk);
    chk("R10 overflow on wrap to zero", 32'(ovf_flag), 1);
    chk("R5 output low with PWM off", 32'(pwm_out), 0);
    wr8(3'd1, 8'd0);
    wr8(3'd6, 8'h00);
    chk("R12 zero write keeps flag", 32'(ovf_flag), 1);
    wr8(3'd6, 8'h01);
    chk("R12 overflow cleared", 32'(ovf_flag), 0);
    chk("R12 compare flag untouched", 32'(cmp_flag), 1);
    wr8(3'd6, 8'h02);
    chk("R12 compare flag cleared", 32'(cmp_flag), 0);

    // R6 counter written above top turns downward
    wr8(3'd0, 8'd0);
    wr16(3'd2, 16'h0150);
    wr8(3'd0, 8'd1);
    rd8(3'd0, b); chk("R5 mode readback", 32'(b), 1);
    wr8(3'd1, 8'd1);
    wr8(3'd1, 8'd0);
    rd16(3'd2, w); chk("R6 above top decrements", 32'(w), 32'h014F);

    // R7 R8 buffering: start at top, active 0x20, pending 0x80
    wr8(3'd0, 8'd0);
    wr16(3'd2, 16'h00FF);
    wr16(3'd4, 16'h0020);
    wr8(3'd0, 8'd1);
    wr16(3'd4, 16'h0080);
    rd16(3'd4, w); chk("R8 read returns pending", 32'(w), 32'h0080);
    wr8(3'd6, 8'h03);
    wr8(3'd1, 8'd1);
    repeat (175) @(negedge clk);   // count 0x50, pending 0x80 passed
    chk("R7 pending not active before top", 32'(pwm_out), 0);
    chk("R7 no match on pending value", 32'(cmp_flag), 0);
    repeat (64) @(negedge clk);    // count 0x10
    chk("R9 set on down match", 32'(pwm_out), 1);
    chk("R11 flag on active match", 32'(cmp_flag), 1);
    chk("R10 not yet at zero", 32'(ovf_flag), 0);
    repeat (16) @(negedge clk);    // count 0
    chk("R10 overflow at zero in PWM", 32'(ovf_flag), 1);
    repeat (31) @(negedge clk);    // count 0x1F going up
    chk("R9 still high below compare", 32'(pwm_out), 1);
    @(negedge clk);                // count 0x20
    chk("R9 clear on up match", 32'(pwm_out), 0);
    repeat (223) @(negedge clk);   // count 0xFF, latch
    repeat (126) @(negedge clk);   // count 0x81
    chk("R7 new value not reached", 32'(pwm_out), 0);
    @(negedge clk);                // count 0x80
    chk("R7 latched value drives set", 32'(pwm_out), 1);
    wr8(3'd1, 8'd0);

    // R9 duty sweep across resolutions and compare corners
    for (int m = 1; m <= 3; m++) begin
      int top;
      top = (1 << (7 + m)) - 1;
      duty(m, 0);
      duty(m, 1);
      duty(m, top / 3);
      duty(m, top - 1);
      duty(m, top);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule